// File: doc/BRIEF.md
# Phase Accumulator Sine Oscillator

This block is a numerically controlled audio oscillator. An 18-bit phase register is stepped by an 18-bit frequency word every time the audio converter reports that it can take a new sample. The ten most significant phase bits select an entry of a 1024-point sine table, and the eight low bits are a fraction that only carries into the index over several samples. The table value is a 12-bit signed sample. It is placed left-justified in an 18-bit output word and presented with a one-cycle strobe.

The frequency word starts at 0x0CD0, which is 440 Hz when samples are taken at 35156.25 Hz. A small command port can restore that preset, double or halve the word (an octave up or down), or move it by one step in either direction. The table is computed at elaboration by a constant function, so no memory image file is needed.

Top module: `nco_sine_osc`

## Requirements
- R1: While `rst_ni` is low at a clock edge, the phase is cleared, the frequency word is set to 0x0CD0, and `dac_data_o` and `dac_strobe_o` are cleared.
- R2: A sample is requested only by bit 3 of `status_i`. The other status bits have no effect on strobes, phase or frequency word.
- R3: When a request is accepted at edge k, `dac_strobe_o` is high for exactly the one cycle after edge k+1.
- R4: The strobed word is T[i] shifted left by 6, with the low 6 bits zero. Here i is phase[17:8] and T[i] = round(2047*sin(2*pi*i/1024)), as a 12-bit two's complement value.
- R5: Each accepted request emits the sample of the phase held before the request. The phase then becomes (phase + frequency word) mod 2^18, using the frequency word in effect before that edge.
- R6: A request is not accepted in the cycle after an accepted request. If bit 3 stays high, samples come on every second edge.
- R7: Command code 1 (preset) sets the frequency word to 0x0CD0 at the next edge.
- R8: Command code 2 (octave up) doubles the frequency word modulo 2^18.
- R9: Command code 3 (octave down) shifts the frequency word right by one place arithmetically, keeping bit 17.
- R10: Command code 4 adds 1 and command code 5 subtracts 1 from the frequency word, both modulo 2^18.
- R11: The frequency word does not change when `cmd_valid_i` is low, or when the code is 0, 6 or 7.
- R12: `dac_data_o` keeps its value in every cycle in which `dac_strobe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| status_i | input | 4 | Converter status; bit 3 requests a sample |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 3 | Command code (1 preset, 2 octave up, 3 octave down, 4 step up, 5 step down) |
| dac_data_o | output | 18 | Left-justified 12-bit signed sample |
| dac_strobe_o | output | 1 | One-cycle write strobe for `dac_data_o` |
| freq_word_o | output | 18 | Current phase increment |

## Verification
The bench keeps its own phase and frequency model and compares every strobed sample with a sine value computed in the bench. A design that added the increment before reading the table, or that used a frequency word changed in the same cycle, would produce samples one step ahead. Halving a negative word and doubling 0x20000 test the shift edges: a logical shift would lose the sign, and an overflowing add would not wrap to zero. Holding the request high catches a design that accepts on every edge and drops samples. Toggling the status bits other than bit 3 catches a decoder that looks at the whole status word.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int PHASE_W = 18;
    localparam int IDX_W   = 10;
    localparam int SAMP_W  = 12;

    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_PRESET  = 3'd1,
        CMD_OCT_UP  = 3'd2,
        CMD_OCT_DN  = 3'd3,
        CMD_STEP_UP = 3'd4,
        CMD_STEP_DN = 3'd5
    } nco_cmd_e;

endpackage

// File: rtl/nco_sine_rom.sv
module nco_sine_rom #(
    parameter int IDX_W  = 10,
    parameter int SAMP_W = 12
) (
    input  logic                     clk_i,
    input  logic [IDX_W-1:0]         addr_i,
    output logic signed [SAMP_W-1:0] data_o
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int AMPL  = (1 << (SAMP_W - 1)) - 1;

    typedef logic signed [SAMP_W-1:0] tab_t [DEPTH];

    function automatic tab_t build_table();
        tab_t t;
        for (int i = 0; i < DEPTH; i++) begin
            real r;
            int  v;
            r = real'(AMPL) * $sin(2.0 * 3.14159265358979323846 * real'(i) / real'(DEPTH));
            if (r >= 0.0) v = $rtoi(r + 0.5);
            else          v = -$rtoi(0.5 - r);
            t[i] = SAMP_W'(v);
        end
        return t;
    endfunction

    localparam tab_t TABLE = build_table();

    logic signed [SAMP_W-1:0] data_q;

    always_ff @(posedge clk_i) begin
        data_q <= TABLE[addr_i];
    end

    assign data_o = data_q;

endmodule

// File: rtl/nco_freq_ctl.sv
module nco_freq_ctl
    import nco_pkg::*;
#(
    parameter int               W       = 18,
    parameter logic [W-1:0]     PRESET  = 18'h00CD0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         cmd_valid_i,
    input  logic [2:0]   cmd_code_i,
    output logic [W-1:0] inc_o
);
    logic [W-1:0] inc_d, inc_q;

    always_comb begin
        inc_d = inc_q;
        if (cmd_valid_i) begin
            unique case (cmd_code_i)
                CMD_PRESET:  inc_d = PRESET;
                CMD_OCT_UP:  inc_d = {inc_q[W-2:0], 1'b0};
                CMD_OCT_DN:  inc_d = {inc_q[W-1], inc_q[W-1:1]};
                CMD_STEP_UP: inc_d = inc_q + W'(1);
                CMD_STEP_DN: inc_d = inc_q - W'(1);
                default:     inc_d = inc_q;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) inc_q <= PRESET;
        else         inc_q <= inc_d;
    end

    assign inc_o = inc_q;

    p_preset_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && cmd_code_i == CMD_PRESET) |=> (inc_o == PRESET));

    p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cmd_valid_i || cmd_code_i == CMD_NONE || cmd_code_i > CMD_STEP_DN)
        |=> $stable(inc_o));

endmodule

// File: rtl/nco_sine_osc.sv
module nco_sine_osc
    import nco_pkg::*;
#(
    parameter int           STAT_W    = 4,
    parameter int           READY_BIT = 3,
    parameter logic [17:0]  PRESET    = 18'h00CD0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [STAT_W-1:0] status_i,
    input  logic              cmd_valid_i,
    input  logic [2:0]        cmd_code_i,
    output logic [17:0]       dac_data_o,
    output logic              dac_strobe_o,
    output logic [17:0]       freq_word_o
);
    localparam int PAD_W = PHASE_W - SAMP_W;

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic               pend;
        logic [PHASE_W-1:0] data;
        logic               strobe;
    } osc_state_t;

    osc_state_t st_d, st_q;
    logic [PHASE_W-1:0]       inc;
    logic signed [SAMP_W-1:0] rom_data;
    logic                     accept;

    nco_freq_ctl #(.W(PHASE_W), .PRESET(PRESET)) u_freq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cmd_valid_i (cmd_valid_i),
        .cmd_code_i  (cmd_code_i),
        .inc_o       (inc)
    );

    nco_sine_rom #(.IDX_W(IDX_W), .SAMP_W(SAMP_W)) u_rom (
        .clk_i  (clk_i),
        .addr_i (st_q.phase[PHASE_W-1 -: IDX_W]),
        .data_o (rom_data)
    );

    always_comb begin
        st_d        = st_q;
        accept      = status_i[READY_BIT] && !st_q.pend;
        st_d.pend   = accept;
        st_d.strobe = st_q.pend;
        if (accept)    st_d.phase = st_q.phase + inc;
        if (st_q.pend) st_d.data  = {rom_data, {PAD_W{1'b0}}};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign dac_data_o   = st_q.data;
    assign dac_strobe_o = st_q.strobe;
    assign freq_word_o  = inc;

    p_strobe_after_accept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept |=> ##1 dac_strobe_o);

    p_single_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dac_strobe_o |=> !dac_strobe_o);

    p_phase_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept |=> (st_q.phase == $past(st_q.phase) + $past(inc)));

    p_no_back_to_back_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept |=> !accept);

    p_low_pad_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dac_strobe_o |-> (dac_data_o[PAD_W-1:0] == '0));

    p_hold_data_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dac_strobe_o |-> $stable(dac_data_o));

endmodule

// File: tb/nco_sine_osc_test.sv
module nco_sine_osc_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  status;
    logic        cmd_valid;
    logic [2:0]  cmd_code;
    logic [17:0] dac_data;
    logic        dac_strobe;
    logic [17:0] freq_word;

    int tests = 0;
    int fails = 0;
    logic [17:0] m_phase;
    logic [17:0] m_inc;
    bit done = 0;

    always #10 clk = ~clk;

    nco_sine_osc uut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .status_i     (status),
        .cmd_valid_i  (cmd_valid),
        .cmd_code_i   (cmd_code),
        .dac_data_o   (dac_data),
        .dac_strobe_o (dac_strobe),
        .freq_word_o  (freq_word)
    );

    function automatic logic [17:0] exp_word(input logic [17:0] ph);
        real r;
        int  v;
        logic [11:0] s;
        r = 2047.0 * $sin(6.283185307179586 * real'(ph[17:8]) / 1024.0);
        v = $rtoi($floor(r + 0.5));
        s = v[11:0];
        return {s, 6'b0};
    endfunction

    function automatic logic [17:0] apply_cmd(input logic [17:0] w, input logic [2:0] c);
        case (c)
            3'd1: return 18'h00CD0;
            3'd2: return w * 2;
            3'd3: return $unsigned($signed(w) >>> 1);
            3'd4: return w + 18'd1;
            3'd5: return w + 18'h3FFFF;
            default: return w;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // one isolated sample request; checks R3/R4/R5
    task automatic one_sample(input logic [2:0] other);
        @(negedge clk);
        status = {1'b1, other};
        @(negedge clk);
        status = {1'b0, other};
        check(dac_strobe == 1'b0, "R3 no early strobe", 32'(dac_strobe), 0);
        @(negedge clk);
        check(dac_strobe == 1'b1, "R3 strobe", 32'(dac_strobe), 1);
        check(dac_data == exp_word(m_phase), "R4 R5 sample", 32'(dac_data), 32'(exp_word(m_phase)));
        m_phase = m_phase + m_inc;
        @(negedge clk);
        check(dac_strobe == 1'b0, "R3 single pulse", 32'(dac_strobe), 0);
    endtask

    task automatic command(input logic [2:0] c, input bit valid);
        @(negedge clk);
        cmd_valid = valid;
        cmd_code  = c;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_code  = 3'd0;
        if (valid) m_inc = apply_cmd(m_inc, c);
        check(freq_word == m_inc, (c == 3'd1) ? "R7 preset" : (c == 3'd2) ? "R8 octave up" :
              (c == 3'd3) ? "R9 octave down" : (c == 3'd4 || c == 3'd5) ? "R10 step" : "R11 ignored",
              32'(freq_word), 32'(m_inc));
    endtask

    task automatic set_inc(input logic [17:0] w);
        // reach w from the model value using only commands: preset, then steps
        command(3'd1, 1'b1);
        while (m_inc != w) command((w > m_inc) ? 3'd4 : 3'd5, 1'b1);
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; status = '0; cmd_valid = 1'b0; cmd_code = '0;
        repeat (3) @(negedge clk);
        check(dac_data == 18'd0, "R1 data", 32'(dac_data), 0);
        check(dac_strobe == 1'b0, "R1 strobe", 32'(dac_strobe), 0);
        check(freq_word == 18'h00CD0, "R1 freq", 32'(freq_word), 32'h0CD0);
        rst_n = 1'b1;
        m_phase = '0;
        m_inc   = 18'h00CD0;

        // R1 phase zero / R4 first samples
        one_sample(3'b000);
        one_sample(3'b101);

        // R2: other status bits alone do nothing
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            status = {1'b0, 3'($urandom_range(1, 7))};
            @(negedge clk);
            check(dac_strobe == 1'b0, "R2 other bits no strobe", 32'(dac_strobe), 0);
            check(freq_word == m_inc, "R2 freq untouched", 32'(freq_word), 32'(m_inc));
        end
        status = '0;
        one_sample(3'b111); // phase untouched by the above (R2)

        // R6: request held high -> strobes on every second edge
        @(negedge clk);
        status = 4'b1000;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i % 2 == 1) begin
                check(dac_strobe == 1'b1, "R6 alternate strobe", 32'(dac_strobe), 1);
                check(dac_data == exp_word(m_phase), "R6 sample", 32'(dac_data), 32'(exp_word(m_phase)));
                m_phase = m_phase + m_inc;
            end else begin
                check(dac_strobe == 1'b0, "R6 gap", 32'(dac_strobe), 0);
            end
        end
        status = 4'b0000;
        @(negedge clk);
        if (dac_strobe) begin
            check(dac_data == exp_word(m_phase), "R6 tail sample", 32'(dac_data), 32'(exp_word(m_phase)));
            m_phase = m_phase + m_inc;
        end
        @(negedge clk);
        check(dac_strobe == 1'b0, "R12 idle", 32'(dac_strobe), 0);

        // R12: data holds while idle
        begin
            logic [17:0] held;
            held = dac_data;
            repeat (4) @(negedge clk);
            check(dac_data == held, "R12 hold", 32'(dac_data), 32'(held));
        end

        // directed frequency corners
        command(3'd5, 1'b1);          // R10 down
        command(3'd4, 1'b1);          // R10 up
        command(3'd2, 1'b1);          // R8
        command(3'd3, 1'b1);          // R9
        command(3'd6, 1'b1);          // R11 unused code
        command(3'd7, 1'b1);          // R11 unused code
        command(3'd0, 1'b1);          // R11 code 0
        command(3'd2, 1'b0);          // R11 valid low
        set_inc(18'h00000);
        command(3'd5, 1'b1);          // R10 0 -> 3FFFF
        command(3'd3, 1'b1);          // R9 negative stays 3FFFF
        command(3'd4, 1'b1);          // R10 wrap to 0
        command(3'd1, 1'b1);          // R7
        repeat (4) command(3'd2, 1'b1); // grow to large word
        repeat (3) one_sample(3'b010);  // R5 wrap exercised
        // 0x0CD0<<4 = 0xCD00; two more doublings -> 0x33400 (bit 17 set)
        command(3'd2, 1'b1);
        command(3'd2, 1'b1);
        command(3'd3, 1'b1);          // R9 sign kept
        repeat (3) one_sample(3'b001);

        // R5 same-edge command and request: sample uses old word
        @(negedge clk);
        status = 4'b1000; cmd_valid = 1'b1; cmd_code = 3'd2;
        @(negedge clk);
        status = 4'b0000; cmd_valid = 1'b0; cmd_code = 3'd0;
        @(negedge clk);
        check(dac_data == exp_word(m_phase), "R5 pre-edge sample", 32'(dac_data), 32'(exp_word(m_phase)));
        m_phase = m_phase + m_inc;
        m_inc   = apply_cmd(m_inc, 3'd2);
        one_sample(3'b000);

        // constrained random mix
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 2) == 0) command(3'($urandom_range(0, 7)), 1'($urandom_range(0, 4) != 0));
            else one_sample(3'($urandom_range(0, 7)));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule